// File: doc/BRIEF.md
# SDRAM Refresh Scheduler with Self-Refresh Control

This block keeps the contents of a synchronous DRAM alive. A free-running interval timer turns the retention period and the row count into a refresh cadence in clock cycles. Each expiry adds one owed refresh to a small saturating counter. While refreshes are owed, the block raises a request toward the command sequencer. When the counter reaches a threshold, it also raises an urgent flag, so that a long data burst can be cut short.

On a grant, the block takes over the command bus. It closes every bank with a precharge-all and waits the precharge time. It then issues an auto-refresh that carries no address, since the memory steps its own row counter. The block holds its busy output for the whole refresh recovery time, so no other command reaches the memory. A sleep request follows the same handshake. It ends in a refresh command issued with clock-enable low, which puts the memory into self refresh. The block then drives only NOP with clock-enable low until a wake request arrives. At wake, it raises clock-enable and stays busy for the exit time.

Commands appear on the row strobe, column strobe and write-enable lines as `{ras_n,cas_n,we_n}`. Chip select is left to the sequencer.

Top module: `rfs_refresh_sched`

## Requirements
- R1: During and right after reset: `cke`=1, command = NOP (`{ras_n,cas_n,we_n}`=3'b111), `a10`=0, `busy`=0, `ref_req`=0, `ref_urgent`=0.
- R2: The refresh interval is I = floor(RETENTION_US*CLK_MHZ/ROWS) cycles, with ROWS either 4096 or 8192. The first owed refresh appears after exactly I clock edges following reset release, and one more is added every I cycles while `cke` is high.
- R3: `ref_req` is high exactly when `busy` is low and either refreshes are owed or `sleep_req` is high. The owed count saturates at 2^PEND_W-1 and never wraps.
- R4: `ref_urgent` is high exactly when the owed count is at least URGENT_LVL.
- R5: A grant sampled while `ref_req` is high and `sleep_req` is low gives, on the next cycle, precharge-all (3'b010 with `a10`=1). Exactly T_RP cycles later comes an auto-refresh (3'b001 with `cke`=1), with NOPs in between. Each auto-refresh removes one owed refresh.
- R6: `busy` rises with the precharge-all. It stays high with NOP on the bus for T_RFC-1 cycles after the auto-refresh, and falls T_RFC cycles after it.
- R7: A grant sampled while `ref_req` is low has no effect: the bus stays NOP and `busy` stays low.
- R8: A grant sampled with `sleep_req` high gives precharge-all, then T_RP cycles later a refresh command with `cke`=0. This clears all owed refreshes, and the interval timer is held at zero while `cke` is low.
- R9: In self refresh, `cke` stays low and the bus stays NOP. Grant and sleep inputs are ignored until `wake_req`.
- R10: `wake_req` in self refresh raises `cke` on the next cycle. `busy` stays high for T_XSR cycles counting that one, then falls, and interval timing restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Sequencer hands the command bus to this block |
| sleep_req | input | 1 | Request to enter self refresh (level) |
| wake_req | input | 1 | Request to leave self refresh |
| ref_req | output | 1 | Block wants the command bus |
| ref_urgent | output | 1 | Owed refreshes at or above threshold |
| busy | output | 1 | Block owns the bus; all banks blocked |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| a10 | output | 1 | All-banks select for precharge |
| cke | output | 1 | Clock enable to the memory |

## Verification
The bench drives the interval edge cycle by cycle. A timer off by one would raise the first request a cycle early or late. The owed count is taken past its maximum before draining. A wrapping counter would drop the urgent flag, or the request, after five missed intervals.

Spacing is measured to the exact cycle. A sequencer counting the wrong wait would put the refresh too close to the precharge, or release `busy` before the recovery time ends. In self refresh, grants and sleep pulses are applied. A block that listened to them would issue commands with clock-enable low. A block that kept owed refreshes or timer state across self refresh would request a refresh right after wake.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
   // command codes on {ras_n, cas_n, we_n}
   localparam logic [2:0] CMD_NOP  = 3'b111;
   localparam logic [2:0] CMD_PREA = 3'b010;
   localparam logic [2:0] CMD_AREF = 3'b001;

   typedef enum logic [3:0] {
      S_IDLE,
      S_AR_PRE,
      S_AR_RP,
      S_AR_REF,
      S_AR_RFC,
      S_SR_PRE,
      S_SR_RP,
      S_SR_ENT,
      S_SR_HOLD,
      S_SR_EXIT
   } rfs_state_e;
endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
   parameter int INTERVAL = 781
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   output logic tick
);
   localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
   localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

   if (INTERVAL < 2) begin : g_bad_interval
      $error("refresh interval must be at least two cycles");
   end

   logic [CW-1:0] cnt_q;

   assign tick = !hold && (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n || hold || tick) cnt_q <= '0;
      else                        cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/rfs_pending_ctr.sv
module rfs_pending_ctr #(
   parameter int PEND_W     = 3,
   parameter int URGENT_LVL = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc,
   input  logic dec,
   input  logic clr,
   output logic nonzero,
   output logic urgent
);
   localparam logic [PEND_W-1:0] PMAX = '1;
   localparam logic [PEND_W-1:0] ULVL = PEND_W'(URGENT_LVL);

   if (PEND_W < 1 || URGENT_LVL < 1 || URGENT_LVL > (2**PEND_W - 1)) begin : g_bad_pend
      $error("urgent level must lie between one and the counter maximum");
   end

   logic [PEND_W-1:0] pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr)                        pend_q <= '0;
      else if (inc && !dec && pend_q != PMAX)   pend_q <= pend_q + 1'b1;
      else if (dec && !inc && pend_q != '0)     pend_q <= pend_q - 1'b1;
   end

   assign nonzero = (pend_q != '0);
   assign urgent  = (pend_q >= ULVL);
endmodule

// File: rtl/rfs_cmd_fsm.sv
module rfs_cmd_fsm
   import rfs_pkg::*;
#(
   parameter int T_RP  = 2,
   parameter int T_RFC = 9,
   parameter int T_XSR = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       gnt,
   input  logic       sleep,
   input  logic       wake,
   input  logic       pend_nz,
   output logic       ref_issue,
   output logic       sr_enter,
   output logic       sr_hold,
   output logic       req,
   output logic       busy,
   output logic [2:0] cmd,
   output logic       a10,
   output logic       cke
);
   localparam int MAXT_A = (T_RP > T_RFC) ? T_RP : T_RFC;
   localparam int MAXT   = (MAXT_A > T_XSR) ? MAXT_A : T_XSR;
   localparam int WW     = $clog2(MAXT + 1);

   if (T_RP < 2 || T_RFC < 2 || T_XSR < 1) begin : g_bad_timing
      $error("precharge and refresh times need two cycles, exit time one");
   end

   rfs_state_e        st_q;
   logic [WW-1:0]     wcnt_q;
   logic              wdone;

   assign wdone = (wcnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         wcnt_q <= '0;
      end else begin
         unique case (st_q)
            S_IDLE: begin
               if (gnt && sleep)        st_q <= S_SR_PRE;
               else if (gnt && pend_nz) st_q <= S_AR_PRE;
            end
            S_AR_PRE: begin
               st_q   <= S_AR_RP;
               wcnt_q <= WW'(T_RP - 2);
            end
            S_AR_RP: begin
               if (wdone) st_q <= S_AR_REF;
               else       wcnt_q <= wcnt_q - 1'b1;
            end
            S_AR_REF: begin
               st_q   <= S_AR_RFC;
               wcnt_q <= WW'(T_RFC - 2);
            end
            S_AR_RFC: begin
               if (wdone) st_q <= S_IDLE;
               else       wcnt_q <= wcnt_q - 1'b1;
            end
            S_SR_PRE: begin
               st_q   <= S_SR_RP;
               wcnt_q <= WW'(T_RP - 2);
            end
            S_SR_RP: begin
               if (wdone) st_q <= S_SR_ENT;
               else       wcnt_q <= wcnt_q - 1'b1;
            end
            S_SR_ENT:  st_q <= S_SR_HOLD;
            S_SR_HOLD: begin
               if (wake) begin
                  st_q   <= S_SR_EXIT;
                  wcnt_q <= WW'(T_XSR - 1);
               end
            end
            S_SR_EXIT: begin
               if (wdone) st_q <= S_IDLE;
               else       wcnt_q <= wcnt_q - 1'b1;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      cmd = CMD_NOP;
      a10 = 1'b0;
      if (st_q == S_AR_PRE || st_q == S_SR_PRE) begin
         cmd = CMD_PREA;
         a10 = 1'b1;
      end else if (st_q == S_AR_REF || st_q == S_SR_ENT) begin
         cmd = CMD_AREF;
      end
   end

   assign ref_issue = (st_q == S_AR_REF);
   assign sr_enter  = (st_q == S_SR_ENT);
   assign sr_hold   = (st_q == S_SR_ENT) || (st_q == S_SR_HOLD);
   assign cke       = !sr_hold;
   assign busy      = (st_q != S_IDLE);
   assign req       = (st_q == S_IDLE) && (pend_nz || sleep);
endmodule

// File: rtl/rfs_refresh_sched.sv
module rfs_refresh_sched #(
   parameter int CLK_MHZ      = 100,
   parameter int RETENTION_US = 64000,
   parameter int ROWS         = 8192,
   parameter int T_RP         = 2,
   parameter int T_RFC        = 9,
   parameter int T_XSR        = 10,
   parameter int PEND_W       = 3,
   parameter int URGENT_LVL   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_gnt,
   input  logic sleep_req,
   input  logic wake_req,
   output logic ref_req,
   output logic ref_urgent,
   output logic busy,
   output logic ras_n,
   output logic cas_n,
   output logic we_n,
   output logic a10,
   output logic cke
);
   localparam int INTERVAL = (RETENTION_US * CLK_MHZ) / ROWS;

   if (ROWS != 4096 && ROWS != 8192) begin : g_bad_rows
      $error("row count must be 4096 or 8192");
   end

   logic       tick, pend_nz, ref_issue, sr_enter, sr_hold;
   logic [2:0] cmd;

   rfs_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (sr_hold),
      .tick  (tick)
   );

   rfs_pending_ctr #(.PEND_W(PEND_W), .URGENT_LVL(URGENT_LVL)) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (tick),
      .dec     (ref_issue),
      .clr     (sr_enter),
      .nonzero (pend_nz),
      .urgent  (ref_urgent)
   );

   rfs_cmd_fsm #(.T_RP(T_RP), .T_RFC(T_RFC), .T_XSR(T_XSR)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .gnt       (ref_gnt),
      .sleep     (sleep_req),
      .wake      (wake_req),
      .pend_nz   (pend_nz),
      .ref_issue (ref_issue),
      .sr_enter  (sr_enter),
      .sr_hold   (sr_hold),
      .req       (ref_req),
      .busy      (busy),
      .cmd       (cmd),
      .a10       (a10),
      .cke       (cke)
   );

   assign {ras_n, cas_n, we_n} = cmd;
endmodule

// File: rtl/rfs_refresh_sched_chk.sv
module rfs_refresh_sched_chk (
   input logic clk,
   input logic rst_n,
   input logic ref_gnt,
   input logic wake_req,
   input logic ref_req,
   input logic busy,
   input logic ras_n,
   input logic cas_n,
   input logic we_n,
   input logic a10,
   input logic cke
);
   logic [2:0] c3;
   assign c3 = {ras_n, cas_n, we_n};

   // R5: every bus ownership starts with a precharge of all banks
   p_prea_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (c3 == 3'b010 && a10));

   // R5: the precharge is followed by a quiet cycle before the refresh
   p_prea_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (c3 == 3'b010) |=> (c3 == 3'b111));

   // R6: after an auto-refresh the bus stays blocked
   p_rfc_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (c3 == 3'b001 && cke) |=> (busy && c3 == 3'b111));

   // R7: the bus is taken only on a grant that met a pending request
   p_gnt_needed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(ref_gnt) && $past(ref_req)));

   // R8: clock-enable falls only together with a refresh command
   p_cke_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cke) |-> (c3 == 3'b001));

   // R9: nothing but NOP while the memory refreshes itself
   p_sr_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke && $past(!cke)) |-> (c3 == 3'b111));

   // R10: clock-enable returns only after a wake request, still busy
   p_cke_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cke) |-> (busy && $past(wake_req)));
endmodule

bind rfs_refresh_sched rfs_refresh_sched_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ref_gnt  (ref_gnt),
   .wake_req (wake_req),
   .ref_req  (ref_req),
   .busy     (busy),
   .ras_n    (ras_n),
   .cas_n    (cas_n),
   .we_n     (we_n),
   .a10      (a10),
   .cke      (cke)
);

// File: tb/rfs_refresh_sched_tb.sv
`timescale 1ns/1ps
module rfs_refresh_sched_tb;
   localparam int CLK_PERIOD = 10;
   localparam int CLK_MHZ    = 2;
   localparam int RET_US     = 64000;
   localparam int ROWS       = 8192;
   localparam int T_RP       = 2;
   localparam int T_RFC      = 9;
   localparam int T_XSR      = 6;
   localparam int PEND_W     = 2;
   localparam int URG        = 2;
   localparam int IVL        = (RET_US * CLK_MHZ) / ROWS;   // 15
   localparam int PMAX       = (1 << PEND_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_gnt = 1'b0, sleep_req = 1'b0, wake_req = 1'b0;
   logic ref_req, ref_urgent, busy, ras_n, cas_n, we_n, a10, cke;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rfs_refresh_sched #(
      .CLK_MHZ(CLK_MHZ), .RETENTION_US(RET_US), .ROWS(ROWS),
      .T_RP(T_RP), .T_RFC(T_RFC), .T_XSR(T_XSR),
      .PEND_W(PEND_W), .URGENT_LVL(URG)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .sleep_req(sleep_req),
      .wake_req(wake_req), .ref_req(ref_req), .ref_urgent(ref_urgent),
      .busy(busy), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .a10(a10), .cke(cke)
   );

   function automatic int c3();
      return int'({ras_n, cas_n, we_n});
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // reference model of owed refreshes, from R2/R3/R4/R5/R8
   int pm = 0;
   int cm = 0;
   always @(negedge clk) begin
      #1;
      if (!rst_n) begin
         pm = 0;
         cm = 0;
      end else if (!done) begin
         chk(ref_req == (!busy && (pm != 0 || sleep_req)), "R3", "ref_req vs model",
             int'(ref_req), int'(!busy && (pm != 0 || sleep_req)));
         chk(ref_urgent == (pm >= URG), "R4", "urgent vs model",
             int'(ref_urgent), int'(pm >= URG));
         begin
            bit sr, tk, dc;
            sr = !cke;
            tk = !sr && (cm == IVL - 1);
            cm = (sr || tk) ? 0 : cm + 1;
            dc = (c3() == 1) && cke;
            if (c3() == 1 && !cke) pm = 0;
            else if (tk && !dc && pm < PMAX) pm++;
            else if (dc && !tk && pm > 0) pm--;
         end
      end
   end

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(cke == 1'b1, "R1", "cke in reset", int'(cke), 1);
      chk(c3() == 7, "R1", "cmd in reset", c3(), 7);
      chk(a10 == 1'b0, "R1", "a10 in reset", int'(a10), 0);
      chk(busy == 1'b0 && ref_req == 1'b0 && ref_urgent == 1'b0, "R1", "req/busy/urgent",
          int'({busy, ref_req, ref_urgent}), 0);
      rst_n = 1'b1;
   endtask

   // R2 and R4: first request after IVL edges, urgent after 2*IVL
   task automatic t_interval();
      int first_req = -1;
      int first_urg = -1;
      for (int k = 1; k <= 2*IVL + 2; k++) begin
         @(negedge clk);
         if (ref_req && first_req < 0) first_req = k;
         if (ref_urgent && first_urg < 0) first_urg = k;
      end
      chk(first_req == IVL, "R2", "first request edge", first_req, IVL);
      chk(first_urg == 2*IVL, "R4", "urgent edge", first_urg, 2*IVL);
   endtask

   // R5/R6: one auto-refresh under grant; caller is at a negedge with ref_req high
   task automatic t_autoref();
      ref_gnt = 1'b1;
      @(negedge clk);
      ref_gnt = 1'b0;
      chk(c3() == 2 && a10, "R5", "precharge-all after grant", c3(), 2);
      chk(busy, "R6", "busy with precharge", int'(busy), 1);
      for (int i = 0; i < T_RP - 1; i++) begin
         @(negedge clk);
         chk(c3() == 7, "R5", "nop in precharge wait", c3(), 7);
      end
      @(negedge clk);
      chk(c3() == 1 && cke, "R5", "auto-refresh at T_RP", c3(), 1);
      for (int i = 0; i < T_RFC - 1; i++) begin
         @(negedge clk);
         chk(busy && c3() == 7 && !ref_req, "R6", "blocked in recovery",
             int'({busy, ref_req}), 2);
      end
      @(negedge clk);
      chk(!busy, "R6", "busy falls at T_RFC", int'(busy), 0);
   endtask

   task automatic t_drain();
      for (int n = 0; n < 20 && ref_req; n++) t_autoref();
      chk(!ref_req, "R5", "owed refreshes drained", int'(ref_req), 0);
   endtask

   // R7: grant without request changes nothing
   task automatic t_stray_grant();
      ref_gnt = 1'b1;
      @(negedge clk);
      ref_gnt = 1'b0;
      chk(c3() == 7 && !busy, "R7", "stray grant ignored", c3(), 7);
   endtask

   // R8/R9/R10: self refresh round trip
   task automatic t_selfref();
      sleep_req = 1'b1;
      @(negedge clk);
      chk(ref_req, "R8", "sleep raises request", int'(ref_req), 1);
      ref_gnt = 1'b1;
      @(negedge clk);
      ref_gnt = 1'b0;
      chk(c3() == 2 && a10 && cke, "R8", "precharge-all before entry", c3(), 2);
      for (int i = 0; i < T_RP - 1; i++) begin
         @(negedge clk);
         chk(c3() == 7 && cke, "R8", "nop before entry", c3(), 7);
      end
      @(negedge clk);
      chk(c3() == 1 && !cke, "R8", "refresh with cke low", int'({c3(), cke}), 2);
      sleep_req = 1'b0;
      for (int i = 0; i < 3*IVL; i++) begin
         ref_gnt   = (i % 3 == 0);
         sleep_req = (i % 5 == 0);
         @(negedge clk);
         chk(!cke && c3() == 7 && busy, "R9", "quiet in self refresh",
             int'({cke, busy}), 1);
      end
      ref_gnt = 1'b0;
      sleep_req = 1'b0;
      wake_req = 1'b1;
      @(negedge clk);
      wake_req = 1'b0;
      chk(cke && busy, "R10", "cke up after wake", int'({cke, busy}), 3);
      for (int i = 0; i < T_XSR - 1; i++) begin
         @(negedge clk);
         chk(busy && c3() == 7, "R10", "busy during exit", int'(busy), 1);
      end
      @(negedge clk);
      chk(!busy, "R10", "busy falls after exit time", int'(busy), 0);
      chk(!ref_req, "R8", "owed refreshes cleared", int'(ref_req), 0);
   endtask

   // R3: five intervals without grant must saturate, not wrap
   task automatic t_saturate();
      for (int k = 0; k < 5*IVL + 4; k++) @(negedge clk);
      chk(ref_urgent, "R3", "saturated count keeps urgent", int'(ref_urgent), 1);
      chk(ref_req, "R3", "saturated count keeps request", int'(ref_req), 1);
      t_drain();
   endtask

   initial begin
      t_reset();
      t_interval();
      t_autoref();
      t_drain();
      t_stray_grant();
      t_selfref();
      t_saturate();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule